// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status and Mask Unit

This unit collects the single-cycle event pulses raised by a network controller's receive, transmit and DMA paths. Each pulse sets a sticky bit in a 32-bit status word. Software reads that word over a small synchronous register port and clears bits by writing ones to them. A second 32-bit register holds the enable bits.

Gating happens in two levels. First, each event bit is ANDed with its own enable bit. The receive results are ORed into a receive summary bit at position 0 of the status word, and the transmit results into a transmit summary bit at position 16. Second, a global enable for each direction, held at the same position in the enable register, passes its summary onto a dedicated interrupt line. The receive line goes to the CPU as `irq_rx` and the transmit line as `irq_tx`.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset the status word, the enable register and the read data are all zero, and both interrupt lines are low.
- R2: A write to the status word (word address 0) clears every event bit whose write-data bit is 1, from the next clock edge on. Event bits written with 0 keep their value.
- R3: Status bit 0 is the receive summary. It reads 1 exactly when some bit in positions 1..11 or 14 is set in both the status word and the enable register.
- R4: `irq_rx` is high exactly when the receive summary is 1 and enable bit 0 is 1. With enable bit 0 at 0 it stays low whatever events are pending.
- R5: Status bit 16 is the transmit summary. It is 1 exactly when some bit in positions 17..24 is set in both the status word and the enable register. `irq_tx` equals that summary ANDed with enable bit 16.
- R6: A pulse on `rx_evt[k]` sets status bit k+1. The defined receive positions are: 1 CRC error, 2 receive overflow, 3 frame too long, 4 good frame, 5 alignment error, 6 runt frame, 7 missed-frame counter wrap, 8 DMA FIFO overflow, 9 early receive notice, 10 receive descriptor unavailable, 11 receive bus error, 14 control frame received. A pulse on `tx_evt[k]` sets status bit k+17. The defined transmit positions are: 17 transmit FIFO empty, 18 transmit done, 19 deferral exceeded, 20 carrier lost, 21 transmit abort, 22 late collision, 23 transmit descriptor unavailable, 24 transmit bus error.
- R7: Status bits 12, 13, 15 and 25..31 are reserved. They always read 0, writes to them do nothing, and pulses on `rx_evt[11]` and `rx_evt[12]` are dropped. In the enable register only bits 0..11, 14 and 16..24 hold a value; the other bits read 0.
- R8: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: The summary bits are read-only. Writing 1 to status bits 0 or 16 changes no stored bit.
- R10: Events are captured into the status word whatever the enable bits hold. Enables act only on the summaries and the interrupt lines.
- R11: A cycle with `reg_sel`=1 and `reg_wr`=0 loads `reg_rdata` at the next edge. Word 0 returns the status word including both summaries, word 1 returns the enable register, and any other word returns 0. Without a read, `reg_rdata` holds its value. A write to word 1 stores the data into the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 14 | Receive/DMA event pulses, bit k maps to status bit k+1 |
| tx_evt | input | 8 | Transmit event pulses, bit k maps to status bit k+17 |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word address (0 status, 1 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_rx | output | 1 | Receive interrupt to CPU |
| irq_tx | output | 1 | Transmit interrupt to CPU |

## Verification
The bench sets every event position on its own and, for each one, sweeps a single enable bit across all 32 positions under all four settings of the two global enables. A wrong bit mapping or a summary that ORs the wrong range would then raise or miss an interrupt on exactly one of those combinations. A pulse and a clear aimed at the same bit in the same cycle are used to show that the event survives. A design where the clear wins would lose that event. The bench also writes ones to the summary and reserved positions and feeds pulses into the dropped receive inputs. A design that stored those bits would read back non-zero where only zeros are legal.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int REG_W    = 32;
  localparam int RX_N     = 14;
  localparam int TX_N     = 8;
  localparam int RX_BASE  = 1;
  localparam int TX_BASE  = 17;
  localparam int RX_SUM   = 0;
  localparam int TX_SUM   = 16;

  // implemented event positions: 1..11, 14 and 17..24
  localparam logic [REG_W-1:0] RX_EVT_MASK = 32'h0000_4FFE;
  localparam logic [REG_W-1:0] TX_EVT_MASK = 32'h01FE_0000;
  localparam logic [REG_W-1:0] EVT_MASK    = RX_EVT_MASK | TX_EVT_MASK;
  localparam logic [REG_W-1:0] SUM_MASK    = (REG_W'(1) << RX_SUM) | (REG_W'(1) << TX_SUM);
  localparam logic [REG_W-1:0] EN_MASK     = EVT_MASK | SUM_MASK;

  // spread the two pulse vectors onto their status positions
  function automatic logic [REG_W-1:0] place_events(input logic [RX_N-1:0] rx,
                                                     input logic [TX_N-1:0] tx);
    logic [REG_W-1:0] v;
    v = (REG_W'(rx) << RX_BASE) | (REG_W'(tx) << TX_BASE);
    return v & EVT_MASK;
  endfunction

  // OR of the status bits that are enabled inside one group
  function automatic logic group_hit(input logic [REG_W-1:0] stat,
                                     input logic [REG_W-1:0] en,
                                     input logic [REG_W-1:0] grp);
    return |(stat & en & grp);
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= set_vec[i] | (q[i] & ~clr_vec[i]);
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  // R2: a clear without a simultaneous set empties the bit
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((q & $past(clr_vec & ~set_vec)) == '0));

  // R8: a set always lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  // R2: untouched bits keep their value
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import mac_irq_pkg::*;
(
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] en,
  output logic             rx_sum,
  output logic             tx_sum,
  output logic             irq_rx,
  output logic             irq_tx
);
  always_comb begin
    rx_sum = group_hit(stat, en, RX_EVT_MASK);
    tx_sum = group_hit(stat, en, TX_EVT_MASK);
    irq_rx = rx_sum & en[RX_SUM];
    irq_tx = tx_sum & en[TX_SUM];
  end
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import mac_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int STAT_WORD = 0,
  parameter int ENAB_WORD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  stat_view,
  output logic [REG_W-1:0]  enab_q,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_WORD);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(ENAB_WORD);

  logic wr_stat, wr_enab, rd_any;

  always_comb begin
    wr_stat = reg_sel & reg_wr & (reg_addr == A_STAT);
    wr_enab = reg_sel & reg_wr & (reg_addr == A_ENAB);
    rd_any  = reg_sel & ~reg_wr;
    clr_vec = wr_stat ? (reg_wdata & EVT_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       enab_q <= '0;
    else if (wr_enab) enab_q <= reg_wdata & EN_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (rd_any) begin
      if (reg_addr == A_STAT)      reg_rdata <= stat_view;
      else if (reg_addr == A_ENAB) reg_rdata <= enab_q;
      else                         reg_rdata <= '0;
    end
  end

  // R11: read data only moves after a read strobe
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(reg_rdata));
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int STAT_WORD = 0,
  parameter int ENAB_WORD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [REG_W-1:0] set_vec, clr_vec, stat_q, enab_q, stat_view;
  logic             rx_sum, tx_sum;

  assign set_vec = place_events(rx_evt, tx_evt);

  irq_sticky_bank #(.W(REG_W), .IMPL(EVT_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(stat_q)
  );

  irq_summary u_sum (
    .stat(stat_q), .en(enab_q),
    .rx_sum(rx_sum), .tx_sum(tx_sum), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  assign stat_view = stat_q | (REG_W'(rx_sum) << RX_SUM) | (REG_W'(tx_sum) << TX_SUM);

  irq_regport #(.ADDR_W(ADDR_W), .STAT_WORD(STAT_WORD), .ENAB_WORD(ENAB_WORD)) u_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_view(stat_view),
    .enab_q(enab_q), .clr_vec(clr_vec), .reg_rdata(reg_rdata)
  );

  // R7: reserved positions never show up in read data
  a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~EN_MASK) == '0));

  // R4: receive interrupt needs a pending enabled event and the global enable
  a_r4_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (enab_q[RX_SUM] && ((stat_q & enab_q & RX_EVT_MASK) != '0)));

  // R5: same for transmit
  a_r5_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (enab_q[TX_SUM] && ((stat_q & enab_q & TX_EVT_MASK) != '0)));

  // R10: a pulse is captured regardless of the enables
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/mac_irq_ctrl_test.sv
module mac_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] rx_evt;
  logic [7:0]  tx_evt;
  logic        reg_sel, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_rx, irq_tx;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_stat, m_en;

  always #4 clk = ~clk;

  mac_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  function automatic bit is_evt(int b);
    return (b >= 1 && b <= 11) || b == 14 || (b >= 17 && b <= 24);
  endfunction

  function automatic logic [31:0] ev_mask();
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) m[b] = is_evt(b);
    return m;
  endfunction

  function automatic logic [31:0] map_ev(logic [13:0] rx, logic [7:0] tx);
    logic [31:0] m = '0;
    for (int k = 0; k < 14; k++) if (rx[k] && is_evt(k + 1)) m[k + 1] = 1'b1;
    for (int k = 0; k < 8; k++)  if (tx[k]) m[k + 17] = 1'b1;
    return m;
  endfunction

  function automatic bit rx_s();
    bit s = 0;
    for (int b = 1; b < 16; b++) s = s | (m_stat[b] & m_en[b]);
    return s;
  endfunction

  function automatic bit tx_s();
    bit s = 0;
    for (int b = 17; b < 32; b++) s = s | (m_stat[b] & m_en[b]);
    return s;
  endfunction

  function automatic logic [31:0] view();
    logic [31:0] v = m_stat;
    v[0] = rx_s();
    v[16] = tx_s();
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
    if (a == 2'd0) m_stat = m_stat & ~d;
    if (a == 2'd1) m_en = d & (ev_mask() | 32'h0001_0001);
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk);
    reg_sel = 0;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [13:0] rx, logic [7:0] tx);
    @(negedge clk);
    rx_evt = rx; tx_evt = tx;
    @(negedge clk);
    rx_evt = '0; tx_evt = '0;
    m_stat = m_stat | map_ev(rx, tx);
  endtask

  task automatic check_state(string tag);
    logic [31:0] d;
    bus_read(2'd0, d);
    chk({tag, " status"}, d, view());
    chk({tag, " irq_rx"}, {31'b0, irq_rx}, {31'b0, rx_s() & m_en[0]});
    chk({tag, " irq_tx"}, {31'b0, irq_tx}, {31'b0, tx_s() & m_en[16]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; rx_evt = '0; tx_evt = '0;
    reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    m_stat = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irqs", {30'b0, irq_rx, irq_tx}, 32'h0);
    bus_read(2'd0, d); chk("R1 status", d, 32'h0);
    bus_read(2'd1, d); chk("R1 enable", d, 32'h0);

    // R6 / R10 / R7: every input pulse alone, enables off
    for (int k = 0; k < 14; k++) begin
      pulse(14'(1) << k, '0);
      check_state("R6 R10 R7 rx map");
      bus_write(2'd0, 32'hFFFF_FFFF);
      check_state("R2 rx clear");
    end
    for (int k = 0; k < 8; k++) begin
      pulse('0, 8'(1) << k);
      check_state("R6 R10 tx map");
      bus_write(2'd0, 32'hFFFF_FFFF);
      check_state("R2 tx clear");
    end

    // R3 R4 R5: each event alone against a sweep of single enable bits
    for (int e = 1; e < 25; e++) begin
      if (is_evt(e)) begin
        bus_write(2'd0, 32'hFFFF_FFFF);
        if (e < 16) pulse(14'(1) << (e - 1), '0);
        else        pulse('0, 8'(1) << (e - 17));
        for (int g = 0; g < 4; g++) begin
          for (int b = 0; b < 32; b++) begin
            bus_write(2'd1, (32'(1) << b) | (g[0] ? 32'h1 : 32'h0) | (g[1] ? 32'h1_0000 : 32'h0));
            check_state("R3 R4 R5 sweep");
          end
        end
      end
    end
    bus_write(2'd0, 32'hFFFF_FFFF);

    // R2 zeros keep, R9 summary read-only, R7 reserved writes ignored
    bus_write(2'd1, 32'hFFFF_FFFF);
    pulse(14'h3FFF, 8'hFF);
    check_state("R7 all pulses");
    bus_write(2'd0, 32'h0);
    check_state("R2 zero write");
    bus_write(2'd0, 32'hFE01_B001);
    check_state("R9 R7 summary and reserved write");
    bus_write(2'd0, 32'h00AA_0A0A);
    check_state("R2 partial clear");

    // R8 set and clear in the same cycle
    bus_write(2'd0, 32'hFFFF_FFFF);
    pulse(14'h0001, 8'h00);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    rx_evt = 14'h0001; tx_evt = 8'h80;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; rx_evt = '0; tx_evt = '0;
    m_stat = map_ev(14'h0001, 8'h80);
    check_state("R8 set wins");

    // R11 / R7 enable readback, unmapped word, hold
    bus_read(2'd1, d); chk("R11 R7 enable mask", d, 32'h01FF_4FFF);
    bus_read(2'd2, d); chk("R11 word 2", d, 32'h0);
    pulse(14'h0002, 8'h00);
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", reg_rdata, 32'h0);
    bus_read(2'd3, d); chk("R11 word 3", d, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule